// File: doc/BRIEF.md
# Program/Erase Sequencer with Status

This block carries out byte programming and block erasure for a flash-style memory once a command decoder has accepted the request. It tells the array when to apply a program or erase pulse, and it reads back a verify result after each pulse. It retries until the verify passes or the retry limit is reached. Pulse length and retry limits are cycle counts set by parameters. The array itself stays outside the block: it sees only pulse strobes and a verify-pass input, so any cell behaviour can be modelled around it.

The 512 KiB space holds seven erase regions of unequal size: a 16 KiB boot region, two 8 KiB parameter regions, one 96 KiB main region and three 128 KiB main regions. A parameter places the boot region at the lowest or the highest addresses, and the second layout is the bit-inverse of the first. Two conditions are checked before any pulse is issued:
- the program supply must report its high level;
- a target in the boot region needs a separate unlock flag.

An erase can be paused so that other regions can be read, and later continued. The block reports progress and sticky error flags in one status byte.

Top module: `pe_sequencer`

## Requirements
- R1: After reset, status reads 0x80, busy is 0 and both strobes are low.
- R2: Status layout: bit 7 ready (1 = idle or paused), bit 6 erase paused, bit 5 erase failure, bit 4 program failure, bit 3 supply-low abort, bits 2..0 always 0.
- R3: A program request that is accepted while idle raises busy and `prog_pulse` on the next cycle. The strobe stays high for PULSE_CYCLES cycles, and one verify cycle follows. If `verify_pass` is 1 in that verify cycle, the block returns to idle.
- R4: If PROG_MAX program pulses all fail verify, bit 4 is set and the block goes idle after exactly PROG_MAX pulses.
- R5: An accepted erase request behaves like a program request, except that it uses `erase_pulse`. A passing verify ends the erase with no error.
- R6: If ERASE_MAX erase pulses all fail verify, bit 5 is set after exactly ERASE_MAX pulses.
- R7: If `vpp_ok` is 0 when a request is accepted, bit 3 is set and no pulse is issued. This check takes precedence over boot protection.
- R8: Bottom layout: region boundaries at 0x03FFF (boot), 0x05FFF, 0x07FFF, 0x1FFFF, 0x3FFFF and 0x5FFFF, with the last region ending at 0x7FFFF.
- R9: With TOP_BOOT=1, every address is bit-inverted before decoding, so the boot region spans 0x7C000..0x7FFFF.
- R10: A boot-region target without `boot_unlock` sets bit 4 for a program or bit 5 for an erase, and issues no pulse. With `boot_unlock` the request runs normally.
- R11: Bits 5..3 are sticky. Only `clr_status_req` clears them, and a set in the same cycle wins over the clear.
- R12: `suspend_req` during an erase stops the strobes on the next cycle and makes the status read 0xC0 (plus any error bits). While paused:
  - `rd_invalid` is 1 exactly for `rd_addr` in the region being erased;
  - new program and erase requests are ignored.
  A suspend during a program has no effect.
- R13: `resume_req` while paused clears bit 6, restarts the interrupted pulse, and keeps the count of pulses already completed, so the ERASE_MAX limit covers the whole erase. A resume when not paused is ignored.
- R14: Requests that arrive while busy are ignored, and the latched address is kept. If program and erase are requested in the same cycle, program wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_req | input | 1 | One-cycle byte program request |
| erase_req | input | 1 | One-cycle block erase request |
| suspend_req | input | 1 | Pause a running erase |
| resume_req | input | 1 | Continue a paused erase |
| clr_status_req | input | 1 | Clear sticky error bits |
| op_addr | input | 19 | Target address of the request |
| op_data | input | 8 | Byte to program |
| vpp_ok | input | 1 | Program supply at high level |
| boot_unlock | input | 1 | Boot region writes allowed |
| verify_pass | input | 1 | Array verify result for the last pulse |
| rd_addr | input | 19 | Address of a concurrent array read |
| status | output | 8 | Status byte |
| busy | output | 1 | Sequencer running pulses or verifies |
| prog_pulse | output | 1 | Program pulse strobe |
| erase_pulse | output | 1 | Erase pulse strobe |
| arr_addr | output | 19 | Latched target address to the array |
| arr_data | output | 8 | Latched program byte to the array |
| rd_invalid | output | 1 | Read hits the paused erase region |

## Verification
The assertions check several properties on every cycle:
- the two strobes never overlap;
- a paused sequencer drives no strobe and flags only reads while paused;
- the error bits stay set until cleared;
- a supply-low or locked-boot request never starts a pulse;
- the retry counter stays within its limit.

The bench's scenarios cover what the assertions cannot. They exercise the region boundaries in both layouts, and they count exact pulses against the retry limits. They confirm that a resumed erase keeps its earlier pulse count. They also show that requests made while busy or paused leave the latched target untouched.

// File: rtl/pe_seq_pkg.sv
// Shared constants and types for the program/erase sequencer.
// Assumes a 512 KiB byte-addressed space split into seven erase regions.
package pe_seq_pkg;
    localparam int ADDR_W = 19;
    localparam int DATA_W = 8;
    localparam int BLK_W  = 3;

    // Upper bound of each region in bottom-boot (normalised) address space
    localparam logic [ADDR_W-1:0] END_BOOT   = 19'h03FFF;
    localparam logic [ADDR_W-1:0] END_PARA   = 19'h05FFF;
    localparam logic [ADDR_W-1:0] END_PARB   = 19'h07FFF;
    localparam logic [ADDR_W-1:0] END_MID    = 19'h1FFFF;
    localparam logic [ADDR_W-1:0] END_BIG0   = 19'h3FFFF;
    localparam logic [ADDR_W-1:0] END_BIG1   = 19'h5FFFF;

    // Status bit positions
    localparam int SB_READY = 7;
    localparam int SB_PAUSE = 6;
    localparam int SB_EFAIL = 5;
    localparam int SB_PFAIL = 4;
    localparam int SB_VLOW  = 3;

    typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_VERIFY, ST_PAUSE} eng_state_t;
    typedef enum logic {OP_PROG, OP_ERASE} op_t;
endpackage

// File: rtl/pe_block_map.sv
// Region decoder: maps a byte address to a region index (0 = boot,
// counting away from the boot end). Assumes a fixed seven-region layout;
// TOP_BOOT mirrors it by inverting the address before decoding.
module pe_block_map
    import pe_seq_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BLK_W-1:0]  blk,
    output logic              is_boot
);
    logic [ADDR_W-1:0] norm;

    // Pick the layout variant
    generate
        if (TOP_BOOT) begin : g_top
            assign norm = ~addr;
        end else begin : g_bottom
            assign norm = addr;
        end
    endgenerate

    // Compare the normalised address against the region bounds
    always_comb begin
        if      (norm <= END_BOOT) blk = 3'd0;
        else if (norm <= END_PARA) blk = 3'd1;
        else if (norm <= END_PARB) blk = 3'd2;
        else if (norm <= END_MID)  blk = 3'd3;
        else if (norm <= END_BIG0) blk = 3'd4;
        else if (norm <= END_BIG1) blk = 3'd5;
        else                       blk = 3'd6;
    end

    assign is_boot = (blk == 3'd0);
endmodule

// File: rtl/pe_engine.sv
// Pulse/verify engine. Accepts a program or erase request while idle,
// screens it for supply level and boot lock, then alternates pulse and
// verify until pass or retry limit. Erase may pause and resume; the count
// of completed pulses survives a pause and the interrupted pulse restarts.
// Assumes verify_pass is valid during the verify cycle.
module pe_engine
    import pe_seq_pkg::*;
#(
    parameter int PULSE_CYCLES = 16,
    parameter int PROG_MAX     = 25,
    parameter int ERASE_MAX    = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic              erase_req,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic [BLK_W-1:0]  tgt_blk,
    input  logic              tgt_boot,
    input  logic              vpp_ok,
    input  logic              boot_unlock,
    input  logic              verify_pass,
    output logic              busy,
    output logic              paused,
    output logic              prog_pulse,
    output logic              erase_pulse,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data,
    output logic [BLK_W-1:0]  pause_blk,
    output logic              set_prog_err,
    output logic              set_erase_err,
    output logic              set_vpp_low
);
    localparam int MAXP  = (PROG_MAX > ERASE_MAX) ? PROG_MAX : ERASE_MAX;
    localparam int CNT_W = $clog2(MAXP + 1);
    localparam int TMR_W = $clog2(PULSE_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(PULSE_CYCLES - 1);

    eng_state_t        state_q;
    op_t               op_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [TMR_W-1:0]  tmr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [BLK_W-1:0]  blk_q;

    logic              idle, req_any, launch_ok, boot_block, pause_now, last_fail;
    logic [CNT_W-1:0]  lim_m1;

    // Request screening and error-set strobes
    always_comb begin
        idle       = (state_q == ST_IDLE);
        req_any    = prog_req || erase_req;
        boot_block = vpp_ok && tgt_boot && !boot_unlock;
        launch_ok  = vpp_ok && !boot_block;
        lim_m1     = (op_q == OP_PROG) ? CNT_W'(PROG_MAX - 1) : CNT_W'(ERASE_MAX - 1);
        pause_now  = suspend_req && (op_q == OP_ERASE);
        last_fail  = (state_q == ST_VERIFY) && !pause_now && !verify_pass && (cnt_q == lim_m1);
        set_vpp_low   = idle && req_any && !vpp_ok;
        set_prog_err  = (idle && prog_req && boot_block) || (last_fail && op_q == OP_PROG);
        set_erase_err = (idle && !prog_req && erase_req && boot_block)
                        || (last_fail && op_q == OP_ERASE);
    end

    // Sequencer state, pulse timer, retry counter and latched target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_PROG;
            cnt_q   <= '0;
            tmr_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            blk_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_any) begin
                        op_q   <= prog_req ? OP_PROG : OP_ERASE;
                        addr_q <= op_addr;
                        data_q <= op_data;
                        blk_q  <= tgt_blk;
                        cnt_q  <= '0;
                        tmr_q  <= '0;
                        if (launch_ok) state_q <= ST_PULSE;
                    end
                end
                ST_PULSE: begin
                    if (pause_now) begin
                        state_q <= ST_PAUSE;
                    end else if (tmr_q == TMR_LAST) begin
                        state_q <= ST_VERIFY;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_VERIFY: begin
                    if (pause_now) begin
                        state_q <= ST_PAUSE;
                    end else if (verify_pass || cnt_q == lim_m1) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                        tmr_q   <= '0;
                        state_q <= ST_PULSE;
                    end
                end
                ST_PAUSE: begin
                    if (resume_req) begin
                        tmr_q   <= '0;
                        state_q <= ST_PULSE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q == ST_PULSE) || (state_q == ST_VERIFY);
    assign paused      = (state_q == ST_PAUSE);
    assign prog_pulse  = (state_q == ST_PULSE) && (op_q == OP_PROG);
    assign erase_pulse = (state_q == ST_PULSE) && (op_q == OP_ERASE);
    assign arr_addr    = addr_q;
    assign arr_data    = data_q;
    assign pause_blk   = blk_q;

    // R7
    vpp_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req_any && !vpp_ok) |=> (state_q == ST_IDLE));

    // R10
    boot_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req_any && tgt_boot && !boot_unlock) |=> !busy);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (cnt_q <= lim_m1));
endmodule

// File: rtl/pe_status.sv
// Status byte: live ready/paused bits from the engine plus three sticky
// error flags. Assumes set strobes last one cycle; a set beats a clear.
module pe_status
    import pe_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              paused,
    input  logic              set_prog_err,
    input  logic              set_erase_err,
    input  logic              set_vpp_low,
    input  logic              clr_req,
    output logic [DATA_W-1:0] status
);
    logic err_e_q, err_p_q, vlow_q;

    // Sticky error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_e_q <= 1'b0;
            err_p_q <= 1'b0;
            vlow_q  <= 1'b0;
        end else begin
            if (set_erase_err)  err_e_q <= 1'b1;
            else if (clr_req)   err_e_q <= 1'b0;
            if (set_prog_err)   err_p_q <= 1'b1;
            else if (clr_req)   err_p_q <= 1'b0;
            if (set_vpp_low)    vlow_q  <= 1'b1;
            else if (clr_req)   vlow_q  <= 1'b0;
        end
    end

    // Assemble the byte
    always_comb begin
        status           = '0;
        status[SB_READY] = !busy;
        status[SB_PAUSE] = paused;
        status[SB_EFAIL] = err_e_q;
        status[SB_PFAIL] = err_p_q;
        status[SB_VLOW]  = vlow_q;
    end

    // R11
    sticky_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_e_q && !clr_req) |=> err_e_q);

    // R11
    sticky_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_p_q && !clr_req) |=> err_p_q);

    // R11
    sticky_vlow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vlow_q && !clr_req) |=> vlow_q);
endmodule

// File: rtl/pe_sequencer.sv
// Top of the program/erase sequencer: region decode for the request and
// for concurrent reads, pulse/verify engine, status byte.
// Assumes one request pulse per command and a single erase in flight.
module pe_sequencer
    import pe_seq_pkg::*;
#(
    parameter bit TOP_BOOT     = 1'b0,
    parameter int PULSE_CYCLES = 16,
    parameter int PROG_MAX     = 25,
    parameter int ERASE_MAX    = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic              erase_req,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic              clr_status_req,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic              vpp_ok,
    input  logic              boot_unlock,
    input  logic              verify_pass,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] status,
    output logic              busy,
    output logic              prog_pulse,
    output logic              erase_pulse,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data,
    output logic              rd_invalid
);
    logic [BLK_W-1:0] tgt_blk, rd_blk, pause_blk;
    logic             tgt_boot, rd_boot, paused;
    logic             set_p, set_e, set_v;

    pe_block_map #(.TOP_BOOT(TOP_BOOT)) u_map_op (
        .addr(op_addr), .blk(tgt_blk), .is_boot(tgt_boot));

    pe_block_map #(.TOP_BOOT(TOP_BOOT)) u_map_rd (
        .addr(rd_addr), .blk(rd_blk), .is_boot(rd_boot));

    pe_engine #(
        .PULSE_CYCLES(PULSE_CYCLES), .PROG_MAX(PROG_MAX), .ERASE_MAX(ERASE_MAX)
    ) u_engine (
        .clk(clk), .rst_n(rst_n),
        .prog_req(prog_req), .erase_req(erase_req),
        .suspend_req(suspend_req), .resume_req(resume_req),
        .op_addr(op_addr), .op_data(op_data),
        .tgt_blk(tgt_blk), .tgt_boot(tgt_boot),
        .vpp_ok(vpp_ok), .boot_unlock(boot_unlock), .verify_pass(verify_pass),
        .busy(busy), .paused(paused),
        .prog_pulse(prog_pulse), .erase_pulse(erase_pulse),
        .arr_addr(arr_addr), .arr_data(arr_data), .pause_blk(pause_blk),
        .set_prog_err(set_p), .set_erase_err(set_e), .set_vpp_low(set_v));

    pe_status u_status (
        .clk(clk), .rst_n(rst_n), .busy(busy), .paused(paused),
        .set_prog_err(set_p), .set_erase_err(set_e), .set_vpp_low(set_v),
        .clr_req(clr_status_req), .status(status));

    // Flag reads into the region held by a paused erase
    assign rd_invalid = paused && (rd_blk == pause_blk);

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_pulse && erase_pulse));

    // R12
    pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[SB_PAUSE] |-> (!prog_pulse && !erase_pulse && !busy));

    // R12
    rd_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_invalid |-> status[SB_PAUSE]);

    // R2
    pause_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[SB_PAUSE] |-> status[SB_READY]);
endmodule

// File: tb/pe_sequencer_tb.sv
`timescale 1ns/1ps
module pe_sequencer_tb;
    localparam int PC = 3;
    localparam int PMAX = 4;
    localparam int EMAX = 6;

    typedef struct packed {
        logic        er;
        logic [18:0] addr;
        logic [3:0]  need;
        logic        vp;
        logic        ul;
        logic [7:0]  st_b;
        logic [7:0]  st_t;
        logic [3:0]  np_b;
        logic [3:0]  np_t;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 19'h10000, 4'd2, 1'b1, 1'b0, 8'h80, 8'h80, 4'd2, 4'd2}, // R3
        '{1'b0, 19'h10000, 4'd5, 1'b1, 1'b0, 8'h90, 8'h90, 4'd4, 4'd4}, // R4
        '{1'b1, 19'h50000, 4'd3, 1'b1, 1'b0, 8'h80, 8'h80, 4'd3, 4'd3}, // R5
        '{1'b1, 19'h50000, 4'd7, 1'b1, 1'b0, 8'hA0, 8'hA0, 4'd6, 4'd6}, // R6
        '{1'b0, 19'h10000, 4'd1, 1'b0, 1'b0, 8'h88, 8'h88, 4'd0, 4'd0}, // R7
        '{1'b1, 19'h00100, 4'd1, 1'b1, 1'b0, 8'hA0, 8'h80, 4'd0, 4'd1}, // R10
        '{1'b1, 19'h7E000, 4'd1, 1'b1, 1'b0, 8'h80, 8'hA0, 4'd1, 4'd0}, // R9
        '{1'b0, 19'h03FFF, 4'd1, 1'b1, 1'b0, 8'h90, 8'h80, 4'd0, 4'd1}, // R8
        '{1'b0, 19'h04000, 4'd1, 1'b1, 1'b0, 8'h80, 8'h80, 4'd1, 4'd1}, // R8
        '{1'b0, 19'h7C000, 4'd1, 1'b1, 1'b0, 8'h80, 8'h90, 4'd1, 4'd0}, // R9
        '{1'b1, 19'h00000, 4'd1, 1'b1, 1'b1, 8'h80, 8'h80, 4'd1, 4'd1}, // R10
        '{1'b1, 19'h03FFF, 4'd1, 1'b0, 1'b0, 8'h88, 8'h88, 4'd0, 4'd0}  // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_req = 0, erase_req = 0, suspend_req = 0, resume_req = 0, clr_req = 0;
    logic [18:0] op_addr = '0, rd_addr = '0;
    logic [7:0]  op_data = '0;
    logic        vpp_ok = 1'b1, boot_unlock = 1'b0;
    logic        verify_b, verify_t;
    logic [7:0]  st_b, st_t, ad_b, ad_t;
    logic        busy_b, busy_t, pp_b, pp_t, ep_b, ep_t, inv_b, inv_t;
    logic [18:0] aa_b, aa_t;

    int errors = 0, checks = 0;
    int need = 1;
    logic clr_cells = 1'b0;
    int cnt_b = 0, run_b = 0, cnt_t = 0, run_t = 0;

    always #10 clk = ~clk;

    pe_sequencer #(.TOP_BOOT(1'b0), .PULSE_CYCLES(PC), .PROG_MAX(PMAX), .ERASE_MAX(EMAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .erase_req(erase_req),
        .suspend_req(suspend_req), .resume_req(resume_req), .clr_status_req(clr_req),
        .op_addr(op_addr), .op_data(op_data), .vpp_ok(vpp_ok), .boot_unlock(boot_unlock),
        .verify_pass(verify_b), .rd_addr(rd_addr), .status(st_b), .busy(busy_b),
        .prog_pulse(pp_b), .erase_pulse(ep_b), .arr_addr(aa_b), .arr_data(ad_b),
        .rd_invalid(inv_b));

    pe_sequencer #(.TOP_BOOT(1'b1), .PULSE_CYCLES(PC), .PROG_MAX(PMAX), .ERASE_MAX(EMAX)) u_dut_top (
        .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .erase_req(erase_req),
        .suspend_req(suspend_req), .resume_req(resume_req), .clr_status_req(clr_req),
        .op_addr(op_addr), .op_data(op_data), .vpp_ok(vpp_ok), .boot_unlock(boot_unlock),
        .verify_pass(verify_t), .rd_addr(rd_addr), .status(st_t), .busy(busy_t),
        .prog_pulse(pp_t), .erase_pulse(ep_t), .arr_addr(aa_t), .arr_data(ad_t),
        .rd_invalid(inv_t));

    // Cell model: a pulse counts only when it lasted the full PC cycles
    always @(negedge clk) begin
        if (clr_cells) begin
            cnt_b <= 0; run_b <= 0; cnt_t <= 0; run_t <= 0;
        end else begin
            if (pp_b || ep_b) run_b <= run_b + 1;
            else begin
                if (run_b == PC) cnt_b <= cnt_b + 1;
                run_b <= 0;
            end
            if (pp_t || ep_t) run_t <= run_t + 1;
            else begin
                if (run_t == PC) cnt_t <= cnt_t + 1;
                run_t <= 0;
            end
        end
    end
    assign verify_b = (cnt_b >= need);
    assign verify_t = (cnt_t >= need);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic clr_status();
        clr_req = 1'b1; step(); clr_req = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while ((busy_b || busy_t) && t < 2000) begin step(); t++; end
        chk(t < 2000, "timeout", t, 0);
        step();
    endtask

    task automatic start_op(input bit er, input logic [18:0] a, input int nd,
                            input bit vp, input bit ul);
        need = nd; vpp_ok = vp; boot_unlock = ul; op_addr = a; op_data = 8'h5A;
        clr_cells = 1'b1; step(); clr_cells = 1'b0;
        if (er) erase_req = 1'b1; else prog_req = 1'b1;
        step();
        prog_req = 1'b0; erase_req = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(st_b == 8'h80 && st_t == 8'h80, "R1 status", st_b, 8'h80);
        chk(!busy_b && !pp_b && !ep_b, "R1 idle", {busy_b, pp_b, ep_b}, 0);

        // Table walk: both layouts, status and full-pulse counts (R2 via full byte)
        for (int i = 0; i < NV; i++) begin
            clr_status();
            start_op(VECS[i].er, VECS[i].addr, int'(VECS[i].need), VECS[i].vp, VECS[i].ul);
            wait_idle();
            chk(st_b == VECS[i].st_b, $sformatf("R2 row%0d bottom status", i), st_b, VECS[i].st_b);
            chk(st_t == VECS[i].st_t, $sformatf("R9 row%0d top status", i), st_t, VECS[i].st_t);
            chk(cnt_b == int'(VECS[i].np_b), $sformatf("R8 row%0d bottom pulses", i), cnt_b, VECS[i].np_b);
            chk(cnt_t == int'(VECS[i].np_t), $sformatf("R9 row%0d top pulses", i), cnt_t, VECS[i].np_t);
        end

        // R3 cycle timing of a program
        clr_status();
        start_op(1'b0, 19'h10000, 1, 1'b1, 1'b0);
        chk(busy_b && pp_b && !st_b[7], "R3 busy next cycle", {busy_b, pp_b, st_b[7]}, 3'b110);
        begin
            int n = 0;
            while (pp_b && n < 20) begin n++; step(); end
            chk(n == PC, "R3 pulse width", n, PC);
        end
        chk(busy_b, "R3 verify cycle busy", busy_b, 1);
        step();
        chk(!busy_b && st_b == 8'h80, "R3 done", st_b, 8'h80);

        // R11 sticky error survives a later success until cleared
        clr_status();
        start_op(1'b0, 19'h10000, 9, 1'b1, 1'b0);
        wait_idle();
        start_op(1'b0, 19'h10000, 1, 1'b1, 1'b0);
        wait_idle();
        chk(st_b == 8'h90, "R11 sticky", st_b, 8'h90);
        clr_status();
        chk(st_b == 8'h80, "R11 cleared", st_b, 8'h80);

        // R12 / R13 pause and resume an erase that finally fails
        start_op(1'b1, 19'h50000, 7, 1'b1, 1'b0);
        while (cnt_b < 2) step();
        while (!ep_b) step();
        suspend_req = 1'b1; step(); suspend_req = 1'b0;
        chk(st_b == 8'hC0 && st_t == 8'hC0, "R12 paused status", st_b, 8'hC0);
        chk(!busy_b && !ep_b, "R12 strobes stop", {busy_b, ep_b}, 0);
        rd_addr = 19'h40000;
        #1;
        chk(inv_b && inv_t, "R12 read same region", {inv_b, inv_t}, 2'b11);
        rd_addr = 19'h60000;
        #1;
        chk(!inv_b && !inv_t, "R12 read other region", {inv_b, inv_t}, 0);
        op_addr = 19'h10000; prog_req = 1'b1; step(); prog_req = 1'b0;
        begin
            bit seen = 0;
            for (int k = 0; k < 5; k++) begin if (pp_b || ep_b) seen = 1; step(); end
            chk(!seen && st_b == 8'hC0 && aa_b == 19'h50000, "R12 request ignored while paused", aa_b, 19'h50000);
        end
        resume_req = 1'b1; step(); resume_req = 1'b0;
        chk(busy_b && !st_b[6] && ep_b, "R13 resume", st_b, 8'h00);
        wait_idle();
        chk(st_b == 8'hA0, "R13 final status", st_b, 8'hA0);
        chk(cnt_b == EMAX, "R13 count kept across pause", cnt_b, EMAX);

        // R12 suspend during program has no effect; R13 stray resume ignored
        clr_status();
        start_op(1'b0, 19'h10000, 3, 1'b1, 1'b0);
        suspend_req = 1'b1; step(); suspend_req = 1'b0;
        chk(busy_b && !st_b[6], "R12 suspend on program ignored", st_b, 8'h00);
        wait_idle();
        chk(st_b == 8'h80 && cnt_b == 3, "R12 program completes", cnt_b, 3);
        resume_req = 1'b1; step(); resume_req = 1'b0;
        chk(!busy_b && st_b == 8'h80, "R13 stray resume", st_b, 8'h80);

        // R14 request while busy ignored
        start_op(1'b0, 19'h10000, 2, 1'b1, 1'b0);
        op_addr = 19'h50000; erase_req = 1'b1; step(); erase_req = 1'b0;
        begin
            bit seen = 0;
            while (busy_b) begin if (ep_b) seen = 1; step(); end
            chk(!seen && aa_b == 19'h10000, "R14 busy request ignored", aa_b, 19'h10000);
        end
        step();

        // R14 simultaneous requests: program wins
        need = 1; op_addr = 19'h20000;
        clr_cells = 1'b1; step(); clr_cells = 1'b0;
        prog_req = 1'b1; erase_req = 1'b1; step(); prog_req = 1'b0; erase_req = 1'b0;
        chk(pp_b && !ep_b, "R14 program priority", {pp_b, ep_b}, 2'b10);
        wait_idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule